// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

An eight-bit storage register with four operations chosen by a two-bit mode input: keep the current value, move every bit one place toward the high end, move every bit one place toward the low end, or capture a word from a shared parallel bus. Rising clock edges commit every operation. An active-low clear empties the register at once, with no clock edge needed.

The parallel bus is bidirectional. The block presents it as three signals: an incoming word, an outgoing word and one drive-enable. The enable turns the outgoing word onto the bus only when both active-low output enables are low and the mode is not capture. A capture therefore always finds the bus released. The register keeps working while the bus is released.

The two end bits also appear on two serial outputs that are always driven. These let a neighbouring register be chained to either end.

Top module: `bidir_univ_shreg`

## Requirements
- R1: With modeSel = 2'b00 a rising edge leaves the stored word unchanged, whatever the serial and bus inputs are.
- R2: With modeSel = 2'b01 a rising edge moves bit n to bit n+1, and serInRight enters bit 0.
- R3: With modeSel = 2'b10 a rising edge moves bit n to bit n-1, and serInLeft enters bit W-1.
- R4: With modeSel = 2'b11 a rising edge copies busIn into the register.
- R5: While clrN is low the register reads all zeros at once, without a clock edge. Rising edges and the mode have no effect while clrN is low.
- R6: With clrN high, the register changes only on a rising clock edge. Input changes between edges leave all outputs unchanged.
- R7: busDrive is 1 exactly when outEnAN = 0, outEnBN = 0 and modeSel is not 2'b11.
- R8: Whenever busDrive is 1, busOut equals the stored word.
- R9: While busDrive is 0, holding, shifting, loading and clearing still update the register. The result appears on busOut once the drivers are re-enabled.
- R10: serOutLow always equals stored bit 0 and serOutHigh always equals bit W-1, regardless of the output enables and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clrN | input | 1 | Active-low asynchronous clear |
| modeSel | input | 2 | 00 keep, 01 toward high end, 10 toward low end, 11 capture bus |
| serInRight | input | 1 | Serial bit entering bit 0 in mode 01 |
| serInLeft | input | 1 | Serial bit entering bit W-1 in mode 10 |
| outEnAN | input | 1 | Active-low bus output enable, first |
| outEnBN | input | 1 | Active-low bus output enable, second |
| busIn | input | W | Word read from the bus in capture mode |
| busOut | output | W | Word offered to the bus |
| busDrive | output | 1 | Bus driver enable; 0 means high impedance |
| serOutLow | output | 1 | Stored bit 0, always driven |
| serOutHigh | output | 1 | Stored bit W-1, always driven |

## Verification
Two functions can land in the same cycle. The first pair is the clear and a capture edge. The bench holds clrN low across a rising edge while capture mode offers an all-ones bus word. It expects both serial outputs to stay 0 and the word read back after release to be zero.

The second pair is bus release and register update. The bench shifts and captures with one output enable high and confirms busDrive is 0. It then re-enables the drivers and compares busOut against the word it predicted for those edges.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_FILL  = 2'b11
  } shiftMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBus;
    logic goRight;
    logic goLeft;
    logic driveBus;
  } ctrlStrobe_t;

endpackage

// File: rtl/ushr_ctrl.sv
module ushr_ctrl
  import ushr_pkg::*;
(
  input  logic        [1:0] modeSel,
  input  logic              outEnAN,
  input  logic              outEnBN,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    unique case (shiftMode_e'(modeSel))
      MODE_RIGHT: strobe.goRight = 1'b1;
      MODE_LEFT:  strobe.goLeft  = 1'b1;
      MODE_FILL:  strobe.takeBus = 1'b1;
      default:    strobe = '0;
    endcase
    // bus released in capture mode or when either enable is high
    strobe.driveBus = !outEnAN && !outEnBN && !strobe.takeBus;
  end

endmodule

// File: rtl/ushr_datapath.sv
module ushr_datapath
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            clrN,
  input  ctrlStrobe_t     strobe,
  input  logic            serInRight,
  input  logic            serInLeft,
  input  logic [W-1:0]    busIn,
  output logic [W-1:0]    regQ
);

  localparam int EXT = W + 2;

  logic [EXT-1:0] ext;
  logic [W-1:0]   nextQ;

  // ext[0] = right serial in, ext[i+1] = regQ[i], ext[W+1] = left serial in
  assign ext = {serInLeft, regQ, serInRight};

  for (genvar i = 0; i < W; i++) begin : g_slice
    always_comb begin
      if (strobe.takeBus)      nextQ[i] = busIn[i];
      else if (strobe.goRight) nextQ[i] = ext[i];
      else if (strobe.goLeft)  nextQ[i] = ext[i+2];
      else                     nextQ[i] = regQ[i];
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) regQ <= '0;
    else       regQ <= nextQ;
  end

  // R1
  p_keep_r1: assert property (@(posedge clk) disable iff (!clrN)
    !(strobe.takeBus || strobe.goRight || strobe.goLeft) |=> $stable(regQ));
  // R2
  p_right_r2: assert property (@(posedge clk) disable iff (!clrN)
    strobe.goRight |=> regQ == {$past(regQ[W-2:0]), $past(serInRight)});
  // R3
  p_left_r3: assert property (@(posedge clk) disable iff (!clrN)
    strobe.goLeft |=> regQ == {$past(serInLeft), $past(regQ[W-1:1])});
  // R4
  p_fill_r4: assert property (@(posedge clk) disable iff (!clrN)
    strobe.takeBus |=> regQ == $past(busIn));

endmodule

// File: rtl/bidir_univ_shreg.sv
module bidir_univ_shreg
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clrN,
  input  logic [1:0]   modeSel,
  input  logic         serInRight,
  input  logic         serInLeft,
  input  logic         outEnAN,
  input  logic         outEnBN,
  input  logic [W-1:0] busIn,
  output logic [W-1:0] busOut,
  output logic         busDrive,
  output logic         serOutLow,
  output logic         serOutHigh
);

  ctrlStrobe_t strobe;
  logic [W-1:0] regQ;

  ushr_ctrl u_ctrl (
    .modeSel (modeSel),
    .outEnAN (outEnAN),
    .outEnBN (outEnBN),
    .strobe  (strobe)
  );

  ushr_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .clrN       (clrN),
    .strobe     (strobe),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .busIn      (busIn),
    .regQ       (regQ)
  );

  assign busOut     = regQ;
  assign busDrive   = strobe.driveBus;
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[W-1];

  // R7
  p_drive_r7: assert property (@(posedge clk) disable iff (!clrN)
    busDrive |-> (!outEnAN && !outEnBN && modeSel != 2'b11));
  // R7
  p_release_r7: assert property (@(posedge clk) disable iff (!clrN)
    (modeSel == 2'b11 || outEnAN || outEnBN) |-> !busDrive);

endmodule

// File: tb/tb_bidir_univ_shreg.sv
`timescale 1ns/1ps
module tb_bidir_univ_shreg;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clrN;
  logic [1:0] modeSel;
  logic       serInRight, serInLeft, outEnAN, outEnBN;
  logic [7:0] busIn, busOut;
  logic       busDrive, serOutLow, serOutHigh;

  int nChecks = 0;
  int nFail   = 0;

  bidir_univ_shreg #(.W(8)) dut (
    .clk(clk), .clrN(clrN), .modeSel(modeSel),
    .serInRight(serInRight), .serInLeft(serInLeft),
    .outEnAN(outEnAN), .outEnBN(outEnBN),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive),
    .serOutLow(serOutLow), .serOutHigh(serOutHigh)
  );

  // {mode[19:18], serInRight[17], serInLeft[16], bus[15:8], expected[7:0]}
  localparam logic [19:0] VEC [12] = '{
    {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},
    {2'b01, 1'b0, 1'b0, 8'h00, 8'h96},
    {2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h65},
    {2'b00, 1'b1, 1'b1, 8'hFF, 8'h65},
    {2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h1E},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h3D},
    {2'b11, 1'b0, 1'b0, 8'h00, 8'h00},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h01},
    {2'b10, 1'b0, 1'b1, 8'h00, 8'h80}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1 keep";
      2'b01:   return "R2 right";
      2'b10:   return "R3 left";
      default: return "R4 capture";
    endcase
  endfunction

  // apply one operation across one rising edge, then park in keep mode
  task automatic stepOp(input logic [1:0] m, input logic sr, input logic sl,
                        input logic [7:0] b);
    @(negedge clk);
    modeSel = m; serInRight = sr; serInLeft = sl; busIn = b;
    @(posedge clk);
    #1 modeSel = 2'b00;
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    clrN = 1'b0; modeSel = 2'b00; serInRight = 1'b0; serInLeft = 1'b0;
    outEnAN = 1'b0; outEnBN = 1'b0; busIn = 8'h00;

    // reset state, R5
    #3;
    chk("R5 reset busOut", busOut, 8'h00);
    chk("R5 reset serial", {6'b0, serOutHigh, serOutLow}, 8'h00);
    @(negedge clk); clrN = 1'b1;

    // R7 drive enable over every enable/mode combination
    for (int k = 0; k < 16; k++) begin
      logic expDrv;
      @(negedge clk);
      outEnAN = k[3]; outEnBN = k[2]; modeSel = k[1:0];
      expDrv = !k[3] && !k[2] && (k[1:0] != 2'b11);
      #1 chk("R7 busDrive", {7'b0, busDrive}, {7'b0, expDrv});
    end
    @(negedge clk); outEnAN = 1'b0; outEnBN = 1'b0; modeSel = 2'b00;

    // table walk, R1 R2 R3 R4 R8
    for (int v = 0; v < 12; v++) begin
      stepOp(VEC[v][19:18], VEC[v][17], VEC[v][16], VEC[v][15:8]);
      chk({modeTag(VEC[v][19:18]), " R8 drive"}, {7'b0, busDrive}, 8'h01);
      chk({modeTag(VEC[v][19:18]), " R8 word"}, busOut, VEC[v][7:0]);
    end

    // R6: inputs change between edges, nothing moves until the edge
    stepOp(2'b11, 1'b0, 1'b0, 8'h5A);
    @(negedge clk);
    modeSel = 2'b01; serInRight = 1'b1; busIn = 8'hFF;
    #2 chk("R6 no edge serial", {6'b0, serOutHigh, serOutLow}, 8'h00);
    @(posedge clk); #1;
    chk("R2 after edge serial", {6'b0, serOutHigh, serOutLow}, 8'h03);
    modeSel = 2'b00; #1;
    chk("R6 R2 word", busOut, 8'hB5);

    // R9 R10: operate while released
    @(negedge clk); outEnAN = 1'b1;
    stepOp(2'b11, 1'b0, 1'b0, 8'hC3);
    chk("R9 released", {7'b0, busDrive}, 8'h00);
    chk("R10 serial C3", {6'b0, serOutHigh, serOutLow}, 8'h03);
    stepOp(2'b01, 1'b0, 1'b0, 8'h00);
    chk("R10 serial 86", {6'b0, serOutHigh, serOutLow}, 8'h02);
    @(negedge clk); outEnAN = 1'b0;
    #1 chk("R9 word after release", busOut, 8'h86);
    @(negedge clk); outEnBN = 1'b1;
    stepOp(2'b10, 1'b0, 1'b0, 8'h00);
    chk("R9 released B", {7'b0, busDrive}, 8'h00);
    chk("R10 serial 43", {6'b0, serOutHigh, serOutLow}, 8'h01);
    @(negedge clk); outEnBN = 1'b0;
    #1 chk("R9 word 43", busOut, 8'h43);

    // R5: clear between edges, and held across a capture edge
    stepOp(2'b11, 1'b0, 1'b0, 8'hFF);
    @(negedge clk);
    #2 clrN = 1'b0;
    #1 chk("R5 clear mid-cycle", busOut, 8'h00);
    modeSel = 2'b11; busIn = 8'hFF;
    @(posedge clk); #1;
    chk("R5 clear beats capture", {6'b0, serOutHigh, serOutLow}, 8'h00);
    @(negedge clk); modeSel = 2'b00; clrN = 1'b1;
    #1 chk("R5 word after clear", busOut, 8'h00);

    // R9: clear while released
    stepOp(2'b11, 1'b0, 1'b0, 8'h81);
    @(negedge clk); outEnAN = 1'b1;
    #2 clrN = 1'b0;
    #1 chk("R9 R10 clear released", {6'b0, serOutHigh, serOutLow}, 8'h00);
    @(negedge clk); clrN = 1'b1; outEnAN = 1'b0;
    #1 chk("R9 cleared word", busOut, 8'h00);

    summary();
    $finish;
  end

endmodule